// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Interlock Unit

This block resolves read-after-write hazards in a five-stage load/store integer pipeline with 32 general registers. The register file is read in decode and written in write-back, so a dependence can only be a read of a value that an older instruction has not yet written. The unit compares the source register numbers of the instruction in the execute-stage register against the destination numbers carried by the two later stage registers. It then steers the two ALU operand multiplexers and the store-data multiplexer so that the newest value reaches the execute stage.

A load's value is not available until the end of the memory stage. When the instruction just behind a load needs that value as an ALU operand or as an address base, forwarding cannot close the gap. The unit then raises a stall, which freezes the program counter and the fetch/decode register, and a bubble request, which loads a no-op into the execute-stage register for one cycle. A store whose only dependence on the load is its data operand does not stall. Its data is patched in the memory stage from the write-back register instead.

The unit is purely combinational. It holds no state and adds no cycle of its own. The surrounding datapath owns the stage registers, the multiplexers, the register file and the memories.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each operand select uses the code 2'b00 for the register-file value, 2'b01 for the write-back (MEM/WB) value and 2'b10 for the memory-stage (EX/MEM) value. A select is 2'b01 when only MEM/WB holds a writing instruction whose destination equals the used source. The code 2'b11 never appears.
- R2: When both EX/MEM and MEM/WB match a used source, the select is 2'b10. The younger value wins.
- R3: A destination of register 0 is never forwarded, whatever the write-enable flag says.
- R4: A stage register whose write-enable flag is 0 is never forwarded from.
- R5: An EX/MEM entry flagged as a load is never forwarded into the execute stage.
- R6: `sel_a` follows rs only when rs is used. `sel_b` follows rt only when rt is used and the instruction is not a store. `sel_sd` follows rt only for a store. Any select whose condition is false is 2'b00.
- R7: `stall` is 1 when ID/EX holds a writing load to a nonzero register, and IF/ID uses that register either as rs or as an rt that is not store data.
- R8: A load followed directly by a store of the loaded register as data raises no stall. Two cycles later `sel_mem_sd` is 1: it is 1 whenever EX/MEM holds a store whose rt equals a nonzero, written MEM/WB destination.
- R9: A source flagged as unused never causes a stall, even if its field matches the load destination.
- R10: `bubble` always equals `stall`. Once the bubble occupies ID/EX, the stall drops, so exactly one bubble is inserted for each load-use pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs | input | 5 | rs field of the instruction in IF/ID |
| ifid_rt | input | 5 | rt field of the instruction in IF/ID |
| ifid_use_rs | input | 1 | IF/ID instruction reads rs |
| ifid_use_rt | input | 1 | IF/ID instruction reads rt |
| ifid_store | input | 1 | IF/ID instruction is a store (rt is store data) |
| idex_rs | input | 5 | rs field in ID/EX |
| idex_rt | input | 5 | rt field in ID/EX |
| idex_use_rs | input | 1 | ID/EX instruction reads rs |
| idex_use_rt | input | 1 | ID/EX instruction reads rt |
| idex_store | input | 1 | ID/EX instruction is a store |
| idex_rd | input | 5 | destination register in ID/EX |
| idex_wen | input | 1 | ID/EX instruction writes a register |
| idex_load | input | 1 | ID/EX instruction is a load |
| exmem_rd | input | 5 | destination register in EX/MEM |
| exmem_wen | input | 1 | EX/MEM instruction writes a register |
| exmem_load | input | 1 | EX/MEM instruction is a load |
| exmem_store | input | 1 | EX/MEM instruction is a store |
| exmem_rt | input | 5 | store-data register of the EX/MEM instruction |
| memwb_rd | input | 5 | destination register in MEM/WB |
| memwb_wen | input | 1 | MEM/WB instruction writes a register |
| sel_a | output | 2 | ALU operand A select |
| sel_b | output | 2 | ALU operand B select |
| sel_sd | output | 2 | execute-stage store-data select |
| sel_mem_sd | output | 1 | memory-stage store-data select (1 = MEM/WB value) |
| stall | output | 1 | hold PC and IF/ID this cycle |
| bubble | output | 1 | load a no-op into ID/EX at the next edge |

## Verification
Every output is a combinational function of the current stage-register contents, so each result is due in the same cycle as the stimulus. The bench applies a pattern, waits one nanosecond for the logic to settle, and samples there, well away from a clock edge. The multi-cycle behaviour of R8 and R10 is checked by stepping the stage contents as the pipeline would advance them, one cycle per step. Each step's outputs are compared before the next step is applied.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int NREGS = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic [AW-1:0] ifid_rs,
  input  logic [AW-1:0] ifid_rt,
  input  logic          ifid_use_rs,
  input  logic          ifid_use_rt,
  input  logic          ifid_store,
  input  logic [AW-1:0] idex_rs,
  input  logic [AW-1:0] idex_rt,
  input  logic          idex_use_rs,
  input  logic          idex_use_rt,
  input  logic          idex_store,
  input  logic [AW-1:0] idex_rd,
  input  logic          idex_wen,
  input  logic          idex_load,
  input  logic [AW-1:0] exmem_rd,
  input  logic          exmem_wen,
  input  logic          exmem_load,
  input  logic          exmem_store,
  input  logic [AW-1:0] exmem_rt,
  input  logic [AW-1:0] memwb_rd,
  input  logic          memwb_wen,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [1:0]    sel_sd,
  output logic          sel_mem_sd,
  output logic          stall,
  output logic          bubble
);

  localparam logic [1:0] FROM_RF  = 2'b00;
  localparam logic [1:0] FROM_WB  = 2'b01;
  localparam logic [1:0] FROM_MEM = 2'b10;

  logic mem_src_ok, wb_src_ok, ld_src_ok;
  assign mem_src_ok = exmem_wen && !exmem_load && (exmem_rd != '0);
  assign wb_src_ok  = memwb_wen && (memwb_rd != '0);
  assign ld_src_ok  = idex_load && idex_wen && (idex_rd != '0);

  function automatic logic [1:0] pick(input logic used, input logic [AW-1:0] src,
                                      input logic mem_ok, input logic [AW-1:0] mem_rd,
                                      input logic wb_ok, input logic [AW-1:0] wb_rd);
    if (!used)                        return FROM_RF;
    else if (mem_ok && mem_rd == src) return FROM_MEM;
    else if (wb_ok && wb_rd == src)   return FROM_WB;
    else                              return FROM_RF;
  endfunction

  assign sel_a  = pick(idex_use_rs, idex_rs, mem_src_ok, exmem_rd, wb_src_ok, memwb_rd);
  assign sel_b  = pick(idex_use_rt && !idex_store, idex_rt, mem_src_ok, exmem_rd, wb_src_ok, memwb_rd);
  assign sel_sd = pick(idex_store, idex_rt, mem_src_ok, exmem_rd, wb_src_ok, memwb_rd);

  assign sel_mem_sd = exmem_store && wb_src_ok && (memwb_rd == exmem_rt);

  logic hit_rs, hit_rt;
  assign hit_rs = ifid_use_rs && (ifid_rs == idex_rd);
  assign hit_rt = ifid_use_rt && !ifid_store && (ifid_rt == idex_rd);

  assign stall  = ld_src_ok && (hit_rs || hit_rt);
  assign bubble = stall;

endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] ifid_rs,
  input logic [AW-1:0] ifid_rt,
  input logic          ifid_use_rs,
  input logic          ifid_use_rt,
  input logic          ifid_store,
  input logic [AW-1:0] idex_rs,
  input logic [AW-1:0] idex_rt,
  input logic          idex_use_rs,
  input logic [AW-1:0] idex_rd,
  input logic          idex_load,
  input logic [AW-1:0] exmem_rd,
  input logic          exmem_wen,
  input logic          exmem_load,
  input logic          exmem_store,
  input logic [AW-1:0] memwb_rd,
  input logic          memwb_wen,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [1:0]    sel_sd,
  input logic          sel_mem_sd,
  input logic          stall,
  input logic          bubble
);
  logic known;
  assign known = !$isunknown({ifid_rs, ifid_rt, ifid_use_rs, ifid_use_rt, ifid_store,
                              idex_rs, idex_rt, idex_use_rs, idex_rd, idex_load,
                              exmem_rd, exmem_wen, exmem_load, exmem_store,
                              memwb_rd, memwb_wen, sel_a, sel_b, sel_sd,
                              sel_mem_sd, stall, bubble});

  always_comb begin
    if (known) begin
      a_r1_no_code3: assert (sel_a != 2'b11 && sel_b != 2'b11 && sel_sd != 2'b11);
      a_r2_mem_first: assert (!(idex_use_rs && exmem_wen && !exmem_load && exmem_rd != '0
                                && exmem_rd == idex_rs) || sel_a == 2'b10);
      a_r3_mem_src_nonzero: assert (sel_a != 2'b10 || (exmem_rd != '0 && exmem_rd == idex_rs));
      a_r3_wb_src_nonzero: assert (sel_a != 2'b01 || (memwb_rd != '0 && memwb_rd == idex_rs));
      a_r5_no_load_fwd: assert (!exmem_load || (sel_a != 2'b10 && sel_b != 2'b10 && sel_sd != 2'b10));
      a_r7_stall_needs_load: assert (!stall || idex_load);
      a_r8_mem_sd_store: assert (!sel_mem_sd || (exmem_store && memwb_wen));
      a_r9_unused_quiet: assert (!stall || ifid_use_rs || (ifid_use_rt && !ifid_store));
      a_r10_pair: assert (stall == bubble);
    end
  end
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.AW(AW)) u_chk (
  .ifid_rs(ifid_rs), .ifid_rt(ifid_rt), .ifid_use_rs(ifid_use_rs),
  .ifid_use_rt(ifid_use_rt), .ifid_store(ifid_store),
  .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_use_rs(idex_use_rs),
  .idex_rd(idex_rd), .idex_load(idex_load),
  .exmem_rd(exmem_rd), .exmem_wen(exmem_wen), .exmem_load(exmem_load),
  .exmem_store(exmem_store), .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
  .sel_a(sel_a), .sel_b(sel_b), .sel_sd(sel_sd), .sel_mem_sd(sel_mem_sd),
  .stall(stall), .bubble(bubble)
);

// File: tb/hazard_fwd_unit_test.sv
`timescale 1ns/1ps
module hazard_fwd_unit_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] ifid_rs, ifid_rt, idex_rs, idex_rt, idex_rd, exmem_rd, exmem_rt, memwb_rd;
  logic ifid_use_rs, ifid_use_rt, ifid_store, idex_use_rs, idex_use_rt, idex_store;
  logic idex_wen, idex_load, exmem_wen, exmem_load, exmem_store, memwb_wen;
  logic [1:0] sel_a, sel_b, sel_sd;
  logic sel_mem_sd, stall, bubble;

  hazard_fwd_unit uut (.*);

  int runs = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear();
    {ifid_rs, ifid_rt, idex_rs, idex_rt, idex_rd, exmem_rd, exmem_rt, memwb_rd} = '0;
    {ifid_use_rs, ifid_use_rt, ifid_store, idex_use_rs, idex_use_rt, idex_store} = '0;
    {idex_wen, idex_load, exmem_wen, exmem_load, exmem_store, memwb_wen} = '0;
  endtask

  function automatic int want(input bit used, input int src);
    int m, w;
    if (!used) return 0;
    w = (memwb_wen && memwb_rd != 0 && memwb_rd == src) ? 1 : 0;
    m = (exmem_wen && !exmem_load && exmem_rd != 0 && exmem_rd == src) ? 2 : 0;
    return (m != 0) ? m : w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    clear();
    #1;
    chk("R1 idle sel_a", sel_a, 0);
    chk("R1 idle sel_b", sel_b, 0);
    chk("R1 idle sel_sd", sel_sd, 0);
    chk("R8 idle sel_mem_sd", sel_mem_sd, 0);
    chk("R7 idle stall", stall, 0);
    chk("R10 idle bubble", bubble, 0);

    // forwarding sweep (R1..R6)
    for (int ra = 0; ra < 4; ra++)
      for (int rb = 0; rb < 4; rb++)
        for (int ed = 0; ed < 4; ed++)
          for (int ef = 0; ef < 4; ef++)
            for (int md = 0; md < 4; md++)
              for (int fl = 0; fl < 16; fl++) begin
                @(negedge clk);
                idex_rs = 5'(ra); idex_rt = 5'(rb);
                exmem_rd = 5'(ed); exmem_wen = ef[0]; exmem_load = ef[1];
                memwb_rd = 5'(md); memwb_wen = fl[0];
                idex_use_rs = fl[1]; idex_use_rt = fl[2]; idex_store = fl[3];
                #1;
                chk("R2 sweep sel_a", sel_a, want(idex_use_rs, ra));
                chk("R6 sweep sel_b", sel_b, want(idex_use_rt && !idex_store, rb));
                chk("R5 sweep sel_sd", sel_sd, want(idex_store, rb));
              end

    // interlock sweep (R7, R9, R10)
    clear();
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int d = 0; d < 4; d++)
          for (int fl = 0; fl < 32; fl++) begin
            bit e;
            @(negedge clk);
            ifid_rs = 5'(a); ifid_rt = 5'(b); idex_rd = 5'(d);
            ifid_use_rs = fl[0]; ifid_use_rt = fl[1]; ifid_store = fl[2];
            idex_wen = fl[3]; idex_load = fl[4];
            #1;
            e = idex_load && idex_wen && d != 0 &&
                ((ifid_use_rs && a == d) || (ifid_use_rt && !ifid_store && b == d));
            chk("R7 sweep stall", stall, int'(e));
            chk("R10 sweep bubble", bubble, int'(e));
          end

    // memory-stage store data sweep (R8)
    clear();
    for (int t = 0; t < 4; t++)
      for (int d = 0; d < 4; d++)
        for (int fl = 0; fl < 4; fl++) begin
          @(negedge clk);
          exmem_store = fl[0]; memwb_wen = fl[1];
          exmem_rt = 5'(t); memwb_rd = 5'(d);
          #1;
          chk("R8 sweep sel_mem_sd", sel_mem_sd, int'(fl[0] && fl[1] && d != 0 && t == d));
        end

    // directed: R3 register 0 with wen set; R4 wen clear
    @(negedge clk); clear();
    idex_use_rs = 1; exmem_wen = 1; memwb_wen = 1; #1;
    chk("R3 r0 not forwarded", sel_a, 0);
    @(negedge clk); clear();
    idex_use_rs = 1; idex_rs = 7; exmem_rd = 7; memwb_rd = 7; #1;
    chk("R4 wen clear not forwarded", sel_a, 0);
    @(negedge clk); clear();
    idex_use_rs = 1; idex_rs = 9; exmem_rd = 9; exmem_wen = 1; memwb_rd = 9; memwb_wen = 1; #1;
    chk("R2 both match", sel_a, 2);
    @(negedge clk); exmem_wen = 0; #1;
    chk("R1 wb only", sel_a, 1);

    // R9: immediate-form rt field matches load dest but unused
    @(negedge clk); clear();
    idex_load = 1; idex_wen = 1; idex_rd = 5;
    ifid_use_rs = 1; ifid_rs = 3; ifid_rt = 5; ifid_use_rt = 0; #1;
    chk("R9 unused rt no stall", stall, 0);

    // R10 sequence: load r5 ; add uses r5
    @(negedge clk); clear();
    idex_load = 1; idex_wen = 1; idex_rd = 5; ifid_use_rs = 1; ifid_rs = 5; #1;
    chk("R10 step1 stall", stall, 1);
    chk("R10 step1 bubble", bubble, 1);
    @(negedge clk);
    idex_load = 0; idex_wen = 0; idex_rd = 0;
    exmem_load = 1; exmem_wen = 1; exmem_rd = 5; #1;
    chk("R10 step2 stall drops", stall, 0);
    @(negedge clk);
    idex_use_rs = 1; idex_rs = 5; ifid_use_rs = 0;
    exmem_load = 0; exmem_wen = 0; exmem_rd = 0;
    memwb_wen = 1; memwb_rd = 5; #1;
    chk("R10 step3 sel_a from wb", sel_a, 1);

    // R8 sequence: load r6 ; store r6 as data
    @(negedge clk); clear();
    idex_load = 1; idex_wen = 1; idex_rd = 6;
    ifid_store = 1; ifid_use_rs = 1; ifid_rs = 2; ifid_use_rt = 1; ifid_rt = 6; #1;
    chk("R8 step1 no stall", stall, 0);
    @(negedge clk); clear();
    idex_store = 1; idex_use_rs = 1; idex_rs = 2; idex_use_rt = 1; idex_rt = 6;
    exmem_load = 1; exmem_wen = 1; exmem_rd = 6; #1;
    chk("R8 step2 sel_sd not from load", sel_sd, 0);
    @(negedge clk); clear();
    exmem_store = 1; exmem_rt = 6; memwb_wen = 1; memwb_rd = 6; #1;
    chk("R8 step3 sel_mem_sd", sel_mem_sd, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule